// File: doc/BRIEF.md
# Secondary Interrupt Router

This block gathers 32 level-sensitive interrupt lines behind a small word-addressed register window of 4 KB. A registered copy of the lines (the raw word) is ANDed with a software enable mask. Any surviving bit raises a single summary request on the top line of a 32-line output bundle that feeds a primary interrupt controller.

Inputs 21 to 30 can also skip the summary. Each one has its own bit in a bypass register. When that bit is set, the raw state of the input drives the output line with the same number directly. When the bit is clear, that line is held low. Software changes the enable mask and the bypass register only through set and clear writes. A separate pair of registers touches enable bit 0 on its own. Read data is returned one cycle after the request.

Top module: `sec_irq_router`

## Requirements
- R1: After reset, the raw word, enable mask, bypass register, read data and all 32 outputs are zero. After that, raw bit i equals input i as sampled at the previous clock edge. A read of word index 1 returns the raw word.
- R2: A read of word index 0 (byte offset divided by 4) returns raw AND enable. A read of index 2 returns the enable mask.
- R3: A write to index 2 ORs the write data into the enable mask. A write to index 3 clears the mask bits where the data has ones.
- R4: A read of index 4 returns raw bit 0 in bit 0, with every other bit zero. A write of any nonzero value to index 4 sets enable bit 0, and to index 5 clears it. A zero write to either index changes nothing.
- R5: A write to index 8 ORs (data AND 32'h7FE00000) into the bypass register, so only bits 21 to 30 can ever be set. A write to index 9 clears the bypass bits where the data has ones. A read of index 8 returns the bypass register.
- R6: For each i from 21 to 30, output i equals raw bit i while bypass bit i is set, and is low otherwise. A bypass change takes effect in the cycle after the write.
- R7: Output 31 is high exactly when raw AND enable is nonzero.
- R8: A read of any index other than 0, 1, 2, 4 and 8 returns zero. A write to any index other than 2, 3, 4, 5, 8 and 9 changes no state.
- R9: Outputs 0 to 20 are always low.
- R10: Read data updates only on the clock edge that accepts a read, and holds its value at all other times. Each accepted access is a full 32-bit word, and the two low address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Level-sensitive interrupt lines |
| sel | input | 1 | Access request, one per cycle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte offset in the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| parent_irq | output | 32 | Lines to the primary controller, with bit 31 as the summary |

## Verification
The hardest case to reach is a bypass bit that changes while its input is toggling and the same input is also enabled in the mask. In that case output 31 and the direct line must agree on the raw state, yet react to different registers. The stimulus sets and clears the bypass register with all-ones data, including bits that are never allowed to stick, between input changes. A long stretch of mixed random accesses and input toggling is then compared on every cycle against a behavioural model. That stretch also hits zero-valued writes to indices 4 and 5, and accesses to indices that do nothing.

// File: rtl/sec_irq_router.sv
module sec_irq_router #(
  parameter int AW    = 12,
  parameter int PT_LO = 21,
  parameter int PT_HI = 30
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] irq_in,
  input  logic        sel,
  input  logic        wr,
  input  logic [AW-1:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [31:0] parent_irq
);
  localparam logic [31:0] PT_MASK =
    ((32'h1 << (PT_HI + 1)) - 32'h1) & ~((32'h1 << PT_LO) - 32'h1);

  logic [31:0] raw, en, pt, rd_mux;
  logic [AW-3:0] idx;
  logic wr_go, rd_go, started;
  logic unused_lsb;

  assign idx        = addr[AW-1:2];
  assign unused_lsb = ^addr[1:0];
  assign wr_go      = sel & wr;
  assign rd_go      = sel & ~wr;

  always_comb begin
    case (idx)
      'd0:     rd_mux = raw & en;
      'd1:     rd_mux = raw;
      'd2:     rd_mux = en;
      'd4:     rd_mux = {31'b0, raw[0]};
      'd8:     rd_mux = pt;
      default: rd_mux = 32'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw     <= '0;
      en      <= '0;
      pt      <= '0;
      rdata   <= '0;
      started <= 1'b0;
    end else begin
      raw     <= irq_in;
      started <= 1'b1;
      if (rd_go) rdata <= rd_mux;
      if (wr_go) begin
        case (idx)
          'd2: en <= en | wdata;
          'd3: en <= en & ~wdata;
          'd4: if (|wdata) en[0] <= 1'b1;
          'd5: if (|wdata) en[0] <= 1'b0;
          'd8: pt <= pt | (wdata & PT_MASK);
          'd9: pt <= pt & ~wdata;
          default: ;
        endcase
      end
    end
  end

  assign parent_irq[30:0] = raw[30:0] & pt[30:0] & PT_MASK[30:0];
  assign parent_irq[31]   = |(raw & en);

  // R1
  raw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> raw == $past(irq_in));

  // R7
  summary_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && idx == 'd0) |=> ((rdata != 0) == $past(parent_irq[31])));

  // R5
  pt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && idx == 'd8) |=> ((rdata & ~PT_MASK) == 32'b0));

  // R6
  pt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && idx == 'd9) |=> ((parent_irq & $past(wdata) & PT_MASK) == 32'b0));

  // R3
  en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && idx == 'd3) |=> ((en & $past(wdata)) == 32'b0));

  // R9
  low_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parent_irq[20:0] == 21'b0);
endmodule

// File: tb/sec_irq_router_test.sv
`timescale 1ns/100ps
module sec_irq_router_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] irq_in = '0, wdata = '0;
  logic sel = 1'b0, wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] rdata, parent_irq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_raw = 0, m_en = 0, m_pt = 0, m_rd = 0;
  string rd_tag = "R1";

  always #2.5 clk = ~clk;

  sec_irq_router uut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .sel(sel), .wr(wr),
    .addr(addr), .wdata(wdata), .rdata(rdata), .parent_irq(parent_irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input int i);
    case (i)
      0: return m_raw & m_en;
      1: return m_raw;
      2: return m_en;
      4: return {31'b0, m_raw[0]};
      8: return m_pt;
      default: return 32'b0;
    endcase
  endfunction

  function automatic string tag_of(input int i);
    case (i)
      0: return "R2";
      1: return "R1";
      2: return "R3";
      4: return "R4";
      8: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic cyc(input logic s, input logic w, input int i, input logic [31:0] d, input logic [31:0] lines);
    logic [31:0] exp_out;
    @(negedge clk);
    sel = s; wr = w; addr = 12'(i * 4) | 12'($urandom_range(0, 3)); wdata = d; irq_in = lines;
    @(posedge clk);
    #1;
    if (s && !w) begin m_rd = model_read(i); rd_tag = tag_of(i); end
    else rd_tag = "R10";
    if (s && w) begin
      case (i)
        2: m_en = m_en | d;
        3: m_en = m_en & ~d;
        4: if (d != 0) m_en[0] = 1'b1;
        5: if (d != 0) m_en[0] = 1'b0;
        8: m_pt = m_pt | (d & 32'h7FE00000);
        9: m_pt = m_pt & ~d;
        default: ;
      endcase
    end
    m_raw = lines;
    exp_out = (m_raw & m_pt & 32'h7FE00000) | ((m_raw & m_en) != 0 ? 32'h80000000 : 32'h0);
    check(rd_tag, rdata, m_rd);
    check("R6", parent_irq & 32'h7FE00000, exp_out & 32'h7FE00000);
    check("R7", {31'b0, parent_irq[31]}, {31'b0, exp_out[31]});
    check("R9", parent_irq & 32'h001FFFFF, 32'h0);
  endtask

  task automatic wr_reg(input int i, input logic [31:0] d); cyc(1, 1, i, d, irq_in); endtask
  task automatic rd_reg(input int i); cyc(1, 0, i, 0, irq_in); endtask
  task automatic lines(input logic [31:0] v); cyc(0, 0, 0, 0, v); endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    irq_in = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #1;
    check("R1", rdata, 0);
    check("R1", parent_irq, 0);
    @(negedge clk); irq_in = 0; rst_n = 1'b1;
    lines(0);
    // R1 raw follows inputs
    lines(32'hA5A5_0F0F); rd_reg(1); lines(32'h0000_0001); rd_reg(1);
    // R2 R3 enable set/clear
    wr_reg(2, 32'hFFFF_0001); rd_reg(2); rd_reg(0);
    lines(32'h0001_0000); rd_reg(0);
    wr_reg(3, 32'hFFFF_0000); rd_reg(2);
    check("R3", rdata, 32'h0000_0001);
    // R4 soft bit 0
    wr_reg(5, 0); rd_reg(2); wr_reg(5, 32'h8); rd_reg(2); lines(1); rd_reg(4);
    check("R4", rdata, 32'h1);
    wr_reg(4, 0); rd_reg(2); wr_reg(4, 32'h100); rd_reg(2); rd_reg(0);
    // R5 R6 bypass
    wr_reg(8, 32'hFFFF_FFFF); rd_reg(8);
    check("R5", rdata, 32'h7FE0_0000);
    lines(32'hFFFF_FFFF); lines(32'h5540_0000); lines(32'h0);
    lines(32'h7FE0_0000); wr_reg(9, 32'h0AA0_0000); lines(32'h7FE0_0000); rd_reg(8);
    wr_reg(9, 32'hFFFF_FFFF); lines(32'hFFFF_FFFF);
    check("R6", parent_irq & 32'h7FFF_FFFF, 32'h0);
    // R8 undefined indices
    for (int i = 0; i < 12; i++) wr_reg(i == 2 || i == 3 || i == 4 || i == 5 || i == 8 || i == 9 ? 11 : i, 32'hFFFF_FFFF);
    wr_reg(1023, 32'hFFFF_FFFF);
    foreach (m_rd[k]) begin end
    for (int i = 0; i < 12; i++) rd_reg(i);
    rd_reg(1023);
    check("R8", rdata, 32'h0);
    // R10 hold
    rd_reg(1); lines(0); lines(32'h1234_5678);
    check("R10", rdata, 32'hFFFF_FFFF);
    // mixed random
    for (int n = 0; n < 3000; n++) begin
      int i;
      logic [31:0] d, l;
      i = $urandom_range(0, 11);
      d = ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom;
      l = ($urandom_range(0, 2) == 0) ? $urandom : irq_in;
      cyc($urandom_range(0, 2) != 0, $urandom_range(0, 1) == 1, i, d, l);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule